// File: doc/BRIEF.md
# One-Time PROM Burn Sequencer

This block sits on the programmer side of a one-time PROM that has no address pins. The PROM is driven through a 4-bit mode bus, an address-advance clock and an 8-bit data port that turns around between writing and reading back. A session begins with a `start` pulse. The sequencer resets the PROM's internal address pointer, switches the programming rails on (shown here only as `prog_en`), and then takes bytes one at a time from a valid/ready stream.

Each byte is burned with an adaptive scheme. A write pulse lasting one millisecond is followed by a read-back, and this repeats until the byte reads back correctly. The byte then gets a reinforcing overwrite lasting as many milliseconds as the attempts it took. After that the sequencer sends four clock pulses to advance the PROM address. A byte that still fails after the maximum number of attempts aborts the session and latches the address at fault. The millisecond time base is a prescaler of `MS_DIV` system clocks.

Stream rules: `in_ready` is high only while the sequencer is idle in inhibit mode, waiting for the next word. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. While a word is in progress `in_ready` stays low, so any pending byte is held by the source with no limit on how long. Outside a session no byte is taken.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset, `mode` is inhibit (1101), and `prog_en`, `in_ready`, `done`, `fail` and `aclk` are all low. On `start`, the mode is address-clear (0101) with `prog_en` low for exactly `MS_DIV` clocks. After that, `prog_en` goes high and the mode becomes inhibit.
- R2: `mode` only ever carries one of four codes: 0101 address clear, 1110 write, 1100 verify, 1101 inhibit.
- R3: `in_ready` is high only in inhibit mode with `prog_en` high, before a word starts. Exactly one byte is taken per word. No byte is taken while a word is in progress or outside a session.
- R4: Each write attempt holds mode 1110 for exactly `MS_DIV` clocks, with `dq_out` equal to the accepted byte and `dq_oe` high. `dq_oe` is high in no other mode.
- R5: `dq_oe` is low for at least one clock, in inhibit mode, before verify mode is selected.
- R6: In verify mode, `dq_in` is compared with the byte. A mismatch starts another write attempt, followed again by inhibit and verify.
- R7: After a match, `attempts` holds X, the number of write attempts made for the word. A single write-mode overwrite of exactly X·`MS_DIV` clocks follows.
- R8: The address advances by four `aclk` pulses, each high for `ACLK_HALF` clocks and low for `ACLK_HALF` clocks, only in inhibit mode. No advance follows the word at `LAST_ADDR`.
- R9: After the word at `LAST_ADDR` is done, the mode is address clear, `prog_en` is low, `done` is high, and no further byte is taken.
- R10: When the `MAX_TRIES`-th verify of a word mismatches, the session aborts. `fail` goes high, `fail_addr` holds the word's address, `prog_en` goes low, the mode is inhibit, and no overwrite is issued.
- R11: A `start` pulse after `done` or `fail` begins a new session from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burn session (taken when idle, done or failed) |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte to burn |
| prog_en | output | 1 | Programming rail enable |
| mode | output | 4 | PROM mode code |
| aclk | output | 1 | PROM address-advance clock |
| dq_out | output | 8 | Data driven to the PROM |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 8 | Data read back from the PROM |
| done | output | 1 | Session finished successfully |
| fail | output | 1 | Session aborted on attempt limit |
| fail_addr | output | ADDR_W | Address of the failing word |
| attempts | output | TRY_W | Write attempts made for the current word |

## Verification
On every cycle, the assertions check the legality of the mode code and that `in_ready` only appears in inhibit with the rails on. They also check that the data driver is off on the clock before verify, that address pulses stay in inhibit mode, that the attempt count never passes its cap, and that the rails are off once the sequencer is done or has failed. Only the bench scenarios can show the timing relations across a whole word. These are the 1 ms pulse widths, an overwrite length that scales with the attempt count, the retry count following the PROM model's behaviour, and each byte landing at the right address. The bench also shows the abort at the attempt limit with its latched address, and a restart afterwards.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;
  localparam logic [3:0] MODE_CLEAR   = 4'b0101;
  localparam logic [3:0] MODE_WRITE   = 4'b1110;
  localparam logic [3:0] MODE_VERIFY  = 4'b1100;
  localparam logic [3:0] MODE_INHIBIT = 4'b1101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FETCH,
    ST_WRITE,
    ST_GAP,
    ST_VERIFY,
    ST_CMP,
    ST_OVER,
    ST_REST,
    ST_STEP,
    ST_DONE,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/prom_ms_tick.sv
module prom_ms_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !hold && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/prom_aclk_pulser.sv
module prom_aclk_pulser #(
  parameter int HALF   = 4,
  parameter int PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic aclk,
  output logic busy,
  output logic fin
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PHASES = 2 * PULSES;
  localparam int LW = $clog2(PHASES + 1);
  localparam logic [PW-1:0] PLAST = PW'(HALF - 1);

  logic [PW-1:0] pcnt;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      left <= '0;
      aclk <= 1'b0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          aclk <= 1'b1;
          pcnt <= '0;
          left <= LW'(PHASES - 1);
        end
      end else if (pcnt == PLAST) begin
        pcnt <= '0;
        if (left == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
          aclk <= 1'b0;
        end else begin
          aclk <= ~aclk;
          left <= left - 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  a_r8_aclk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !aclk);
  a_r8_fin_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy && !aclk);
endmodule

// File: rtl/prom_seq_fsm.sv
module prom_seq_fsm
  import prom_burn_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int LAST_ADDR = 'h1F7F,
  parameter int MAX_TRIES = 25,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [7:0]        dq_in,
  input  logic              ms_tick,
  output logic              tick_hold,
  output logic              step_go,
  input  logic              step_fin,
  output logic              prog_en,
  output logic [3:0]        mode,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [TRY_W-1:0]  attempts
);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(LAST_ADDR);
  localparam logic [TRY_W-1:0]  CAP      = TRY_W'(MAX_TRIES);

  seq_state_e          state;
  logic [ADDR_W-1:0]   addr;
  logic [7:0]          word_q;
  logic [TRY_W-1:0]    tries;
  logic [TRY_W-1:0]    ms_done;
  logic                at_end;
  logic                can_start;

  assign at_end    = (addr == END_ADDR);
  assign can_start = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
  assign in_ready  = (state == ST_FETCH);
  assign tick_hold = !((state == ST_CLEAR) || (state == ST_WRITE) || (state == ST_OVER));
  assign step_go   = (state == ST_REST) && !at_end;
  assign dq_oe     = (state == ST_WRITE) || (state == ST_OVER);
  assign dq_out    = word_q;
  assign done      = (state == ST_DONE);
  assign fail      = (state == ST_FAIL);
  assign attempts  = tries;

  always_comb begin
    unique case (state)
      ST_CLEAR, ST_DONE:  mode = MODE_CLEAR;
      ST_WRITE, ST_OVER:  mode = MODE_WRITE;
      ST_VERIFY, ST_CMP:  mode = MODE_VERIFY;
      default:            mode = MODE_INHIBIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr      <= '0;
      word_q    <= '0;
      tries     <= '0;
      ms_done   <= '0;
      prog_en   <= 1'b0;
      fail_addr <= '0;
    end else begin
      unique case (state)
        ST_CLEAR: if (ms_tick) begin
          prog_en <= 1'b1;
          state   <= ST_FETCH;
        end
        ST_FETCH: if (in_valid) begin
          word_q <= in_data;
          tries  <= TRY_W'(1);
          state  <= ST_WRITE;
        end
        ST_WRITE:  if (ms_tick) state <= ST_GAP;
        ST_GAP:    state <= ST_VERIFY;
        ST_VERIFY: state <= ST_CMP;
        ST_CMP: begin
          if (dq_in == word_q) begin
            ms_done <= '0;
            state   <= ST_OVER;
          end else if (tries == CAP) begin
            fail_addr <= addr;
            prog_en   <= 1'b0;
            state     <= ST_FAIL;
          end else begin
            tries <= tries + 1'b1;
            state <= ST_WRITE;
          end
        end
        ST_OVER: if (ms_tick) begin
          if (ms_done == tries - 1'b1) state <= ST_REST;
          else                         ms_done <= ms_done + 1'b1;
        end
        ST_REST: begin
          if (at_end) begin
            prog_en <= 1'b0;
            state   <= ST_DONE;
          end else begin
            state <= ST_STEP;
          end
        end
        ST_STEP: if (step_fin) begin
          addr  <= addr + 1'b1;
          state <= ST_FETCH;
        end
        default: if (can_start && start) begin
          addr    <= '0;
          tries   <= '0;
          prog_en <= 1'b0;
          state   <= ST_CLEAR;
        end
      endcase
    end
  end

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_CLEAR || mode == MODE_WRITE || mode == MODE_VERIFY || mode == MODE_INHIBIT);
  a_r3_ready_in_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> prog_en && mode == MODE_INHIBIT);
  a_r5_oe_off_before_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_VERIFY) |-> !dq_oe && !$past(dq_oe));
  a_r10_tries_capped: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= CAP);
  a_r9_rails_off_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !prog_en);
  a_r4_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mode == MODE_WRITE);
endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
  import prom_burn_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int LAST_ADDR = 'h1F7F,
  parameter int MAX_TRIES = 25,
  parameter int MS_DIV    = 125000,
  parameter int ACLK_HALF = 4,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              prog_en,
  output logic [3:0]        mode,
  output logic              aclk,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic [7:0]        dq_in,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [TRY_W-1:0]  attempts
);
  localparam int STEP_PULSES = 4;

  logic ms_tick, tick_hold, step_go, step_fin, step_busy;

  prom_ms_tick #(.DIV(MS_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (tick_hold),
    .tick (ms_tick)
  );

  prom_aclk_pulser #(.HALF(ACLK_HALF), .PULSES(STEP_PULSES)) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (step_go),
    .aclk (aclk),
    .busy (step_busy),
    .fin  (step_fin)
  );

  prom_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .LAST_ADDR(LAST_ADDR),
    .MAX_TRIES(MAX_TRIES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .dq_in    (dq_in),
    .ms_tick  (ms_tick),
    .tick_hold(tick_hold),
    .step_go  (step_go),
    .step_fin (step_fin),
    .prog_en  (prog_en),
    .mode     (mode),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .done     (done),
    .fail     (fail),
    .fail_addr(fail_addr),
    .attempts (attempts)
  );

  a_r8_step_in_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    step_busy |-> mode == MODE_INHIBIT);
  a_r8_no_step_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    aclk |-> !dq_oe);
endmodule

// File: tb/prom_burn_seq_tb.sv
module prom_burn_seq_tb;
  localparam int ADDR_W = 13;
  localparam int LAST   = 5;
  localparam int NW     = LAST + 1;
  localparam int MAXT   = 4;
  localparam int DIV    = 20;
  localparam int HALF   = 2;
  localparam int TRY_W  = $clog2(MAXT + 1);
  localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110, M_VF = 4'b1100, M_INH = 4'b1101;

  // {byte, attempts the PROM model needs}
  localparam logic [11:0] VEC [NW] = '{
    {8'hA5, 4'd1}, {8'h3C, 4'd3}, {8'hFF, 4'd2},
    {8'h00, 4'd1}, {8'h5A, 4'd4}, {8'hC3, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, prog_en, aclk, dq_oe, done, fail;
  logic [3:0] mode;
  logic [7:0] dq_out, dq_in;
  logic [ADDR_W-1:0] fail_addr;
  logic [TRY_W-1:0] attempts;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  prom_burn_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST), .MAX_TRIES(MAXT),
                  .MS_DIV(DIV), .ACLK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .prog_en(prog_en), .mode(mode),
    .aclk(aclk), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .done(done),
    .fail(fail), .fail_addr(fail_addr), .attempts(attempts));

  // PROM model and protocol monitor
  logic [7:0] mem [8];
  logic [3:0] wcnt [8];
  logic [3:0] need_m [8];
  logic [7:0] edges = '0, tot_edges = '0;
  logic aclk_q = 1'b0, oe_q = 1'b0;
  int hi_len = 0, wr_len = 0, runs = 0, sum = 0, last_run = 0;
  int aclk_bad = 0, oe_bad = 0, rdy_bad = 0;
  logic [2:0] cur;
  assign cur = edges[4:2];
  assign dq_in = (wcnt[cur] >= need_m[cur]) ? mem[cur] : ~mem[cur];

  initial begin
    for (int i = 0; i < 8; i++) begin mem[i] = '0; wcnt[i] = '0; need_m[i] = 4'd1; end
  end

  always @(negedge clk) begin
    if (mode == M_CLR) begin
      edges <= '0;
      for (int i = 0; i < 8; i++) wcnt[i] <= '0;
    end else if (aclk && !aclk_q) edges <= edges + 1'b1;
    if (start) tot_edges <= '0;
    else if (aclk && !aclk_q) tot_edges <= tot_edges + 1'b1;
    aclk_q <= aclk;
    if (aclk) hi_len <= hi_len + 1;
    else begin
      if (hi_len != 0 && hi_len != HALF) aclk_bad <= aclk_bad + 1;
      hi_len <= 0;
    end
    if (aclk && mode != M_INH) aclk_bad <= aclk_bad + 1;
    if (mode == M_WR) begin
      wr_len <= wr_len + 1;
      if (dq_oe) mem[cur] <= dq_out;
    end else if (wr_len != 0) begin
      runs <= runs + 1; sum <= sum + wr_len; last_run <= wr_len;
      wcnt[cur] <= wcnt[cur] + 1'b1; wr_len <= 0;
    end
    if (in_valid && in_ready) begin runs <= 0; sum <= 0; last_run <= 0; end
    if ((dq_oe && mode != M_WR) || (mode == M_VF && oe_q)) oe_bad <= oe_bad + 1;
    oe_q <= dq_oe;
    if (in_ready && (mode != M_INH || !prog_en)) rdy_bad <= rdy_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick_session();
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (mode == M_CLR && !prog_en && n < 10 * DIV) begin n++; @(negedge clk); end
    chk(n == DIV, "R1 clear-mode length", n, DIV);
    chk(mode == M_INH && prog_en, "R1 inhibit with rails on", int'(mode), int'(M_INH));
  endtask

  task automatic send_word(input logic [7:0] d, input int need, input bit expect_fail);
    int g = 0;
    in_data = d; in_valid = 1'b1;
    while (!in_ready && g < 5000) begin g++; @(negedge clk); end
    @(negedge clk); in_valid = 1'b0;
    chk(!in_ready, "R3 ready low during word", int'(in_ready), 0);
    g = 0;
    while (!(in_ready || done || fail) && g < 20000) begin g++; @(negedge clk); end
    if (expect_fail) begin
      chk(fail == 1'b1, "R10 fail flag", int'(fail), 1);
      chk(runs == MAXT && last_run == DIV, "R10 no overwrite", runs, MAXT);
    end else begin
      chk(int'(attempts) == need, "R7 attempt count", int'(attempts), need);
      chk(runs == need + 1, "R6 retry count", runs, need + 1);
      chk(last_run == need * DIV, "R7 overwrite length", last_run, need * DIV);
      chk(sum == 2 * need * DIV, "R4 write pulse widths", sum, 2 * need * DIV);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == M_INH && !prog_en && !in_ready && !done && !fail && !aclk,
        "R1 reset state", int'(mode), int'(M_INH));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Session 1: table walk, all words pass
    for (int i = 0; i < NW; i++) need_m[i] = VEC[i][3:0];
    kick_session();
    for (int i = 0; i < NW; i++) send_word(VEC[i][11:4], int'(VEC[i][3:0]), 1'b0);
    chk(done && !prog_en && mode == M_CLR, "R9 end of session", int'(mode), int'(M_CLR));
    chk(tot_edges == 8'(4 * LAST), "R8 address pulses", int'(tot_edges), 4 * LAST);
    for (int i = 0; i < NW; i++)
      chk(mem[i] == VEC[i][11:4], "R8 byte at its address", int'(mem[i]), int'(VEC[i][11:4]));
    chk(aclk_bad == 0, "R8 pulse width and mode", aclk_bad, 0);
    chk(oe_bad == 0, "R5 driver off before verify", oe_bad, 0);
    chk(rdy_bad == 0, "R3 ready only in inhibit", rdy_bad, 0);

    // R3: byte offered after the session is not taken
    in_valid = 1'b1; in_data = 8'h77;
    repeat (50) @(negedge clk);
    chk(!in_ready && done && mode == M_CLR, "R3 no take outside session", int'(in_ready), 0);
    in_valid = 1'b0;
    @(negedge clk);

    // Session 2: word 2 never reads back, abort at the cap
    need_m[0] = 4'd1; need_m[1] = 4'd1; need_m[2] = 4'd5;
    kick_session();
    send_word(8'h11, 1, 1'b0);
    send_word(8'h22, 1, 1'b0);
    send_word(8'h33, 5, 1'b1);
    chk(int'(fail_addr) == 2, "R10 failing address", int'(fail_addr), 2);
    chk(int'(attempts) == MAXT, "R10 attempts at cap", int'(attempts), MAXT);
    chk(!prog_en && mode == M_INH && !done, "R10 rails off in inhibit", int'(mode), int'(M_INH));

    // Session 3: restart after abort
    for (int i = 0; i < 8; i++) need_m[i] = 4'd1;
    kick_session();
    for (int i = 0; i < NW; i++) send_word(8'(i * 17 + 1), 1, 1'b0);
    chk(done && !fail, "R11 restart completes", int'(done), 1);
    chk(mem[LAST] == 8'(LAST * 17 + 1), "R11 last byte placed", int'(mem[LAST]), LAST * 17 + 1);
    chk(oe_bad == 0 && rdy_bad == 0 && aclk_bad == 0, "R2 protocol clean", oe_bad + rdy_bad + aclk_bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule